// File: doc/BRIEF.md
# Instruction-Cache Range Invalidation Sequencer

This block clears a span of addresses from an instruction cache by driving a mask-based area-invalidate engine. A request carries a start address and an end address (exclusive). The block picks one power-of-two area size for the whole span and writes the matching mask to the engine once. It then aligns the start down to that mask and issues invalidate commands at that stride until the next base reaches or passes the end. The engine's busy flag is honoured before the mask write and between commands.

The size comes from the number of cache lines the span covers. The line size is doubled once for each significant bit of `(end - start - 1) / LINE_BYTES`. The size is capped at 2^(ADDR_W-1). If the cache is disabled, the request completes at once and nothing is written to the engine. The engine and the cache storage sit outside this block.

Top module: `ic_range_inv`

## Requirements
- R1: When `ic_enable` is low at acceptance, `req_done` pulses and no register write is made.
- R2: The area size is LINE_BYTES doubled once per bit of the bit length of `(end - start - 1) >> log2(LINE_BYTES)`, with 32-bit modular subtraction.
- R3: Exactly one mask write (`reg_sel` = 0) is made per enabled request, before any command. Its data is `~(area - 1)`.
- R4: The mask write and every command are made only after `eng_busy` has been sampled low. No write is made while `eng_busy` is high.
- R5: The first command base is `start & mask`.
- R6: A command is a write with `reg_sel` = 1 whose data is the current base ORed with the invalidate flag in bit 0.
- R7: After each command completes, the base grows by the area size. Commands repeat while the base, held one bit wider than the address, is below end.
- R8: The area size saturates at 2^31, giving mask 0x80000000, when the doubling would exceed it. This covers end at or below start.
- R9: `req_done` is high for exactly one cycle per accepted request, after the last command has completed.
- R10: `req_valid` is ignored while a request is in progress.
- R11: After reset there are no register writes and `req_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_start | input | 32 | First address of the span |
| req_end | input | 32 | Address one past the span |
| req_done | output | 1 | One-cycle completion pulse |
| ic_enable | input | 1 | Instruction cache enabled |
| reg_wr | output | 1 | Engine register write strobe |
| reg_sel | output | 1 | 0 = mask register, 1 = command register |
| reg_wdata | output | 32 | Engine register write data |
| eng_busy | input | 1 | Engine still processing a command |

## Verification
The main function is tried on several kinds of span:
- A line-aligned span that needs one command.
- A single line.
- Spans that straddle an area boundary and so need two commands.
- A span near the top of the address space, where the base must not wrap.
- Spans with end equal to or below start, which force the saturated mask.
- A span starting at address zero.

The mask value separates the area-size rule from a per-chunk choice. The command count and the last command separate the end-compare rule from an off-by-one or a wrapping compare. Holding busy high before the first write and raising a second request mid-run separate the wait and the idle-only acceptance from a free-running sequencer.

// File: rtl/icri_pkg.sv
package icri_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PREWAIT  = 3'd1,
        ST_ISSUE    = 3'd2,
        ST_SETTLE   = 3'd3,
        ST_POSTWAIT = 3'd4
    } seq_state_e;

    localparam logic SEL_MASK = 1'b0;
    localparam logic SEL_CMD  = 1'b1;

endpackage

// File: rtl/ic_area_sizer.sv
module ic_area_sizer #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16
) (
    input  logic [ADDR_W-1:0] span_start,
    input  logic [ADDR_W-1:0] span_end,
    output logic [ADDR_W-1:0] area,
    output logic [ADDR_W-1:0] mask
);
    localparam int LINE_SHIFT = $clog2(LINE_BYTES);
    localparam int BLW        = $clog2(ADDR_W + 1);
    localparam int SHW        = BLW + 1;

    logic [ADDR_W-1:0] span_m1;
    logic [ADDR_W-1:0] lines;
    logic [BLW-1:0]    bitlen;
    logic [SHW-1:0]    shamt;

    always_comb begin
        span_m1 = span_end - span_start - ADDR_W'(1);
        lines   = span_m1 >> LINE_SHIFT;
        bitlen  = '0;
        for (int i = 0; i < ADDR_W; i++) begin
            if (lines[i]) bitlen = BLW'(i + 1);
        end
        shamt = SHW'(LINE_SHIFT) + SHW'(bitlen);
        if (shamt >= SHW'(ADDR_W - 1)) begin
            area = {1'b1, {(ADDR_W-1){1'b0}}};
        end else begin
            area = ADDR_W'(1) << shamt;
        end
        mask = ~(area - ADDR_W'(1));
    end

endmodule

// File: rtl/ic_inv_seq.sv
module ic_inv_seq
    import icri_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_end,
    input  logic              ic_enable,
    input  logic              eng_busy,
    input  logic [ADDR_W-1:0] area_i,
    input  logic [ADDR_W-1:0] mask_i,
    output logic [ADDR_W-1:0] span_start_o,
    output logic [ADDR_W-1:0] span_end_o,
    output logic              wr_o,
    output logic              sel_o,
    output logic [ADDR_W-1:0] wdata_o,
    output logic              done_o
);
    localparam logic [ADDR_W-1:0] INV_FLAG = ADDR_W'(1);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] start;
        logic [ADDR_W-1:0] lim;
        logic [ADDR_W:0]   base;
        logic              wr;
        logic              sel;
        logic [ADDR_W-1:0] wdata;
        logic              done;
    } seq_regs_t;

    seq_regs_t       r_q, r_d;
    logic [ADDR_W:0] next_base;

    always_comb begin
        r_d       = r_q;
        r_d.wr    = 1'b0;
        r_d.done  = 1'b0;
        next_base = r_q.base + {1'b0, area_i};
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.start = req_start;
                    r_d.lim   = req_end;
                    if (ic_enable) r_d.st   = ST_PREWAIT;
                    else           r_d.done = 1'b1;
                end
            end
            ST_PREWAIT: begin
                if (!eng_busy) begin
                    r_d.wr    = 1'b1;
                    r_d.sel   = SEL_MASK;
                    r_d.wdata = mask_i;
                    r_d.base  = {1'b0, r_q.start & mask_i};
                    r_d.st    = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                r_d.wr    = 1'b1;
                r_d.sel   = SEL_CMD;
                r_d.wdata = r_q.base[ADDR_W-1:0] | INV_FLAG;
                r_d.st    = ST_SETTLE;
            end
            ST_SETTLE: begin
                r_d.st = ST_POSTWAIT;
            end
            ST_POSTWAIT: begin
                if (!eng_busy) begin
                    r_d.base = next_base;
                    if (next_base < {1'b0, r_q.lim}) begin
                        r_d.st = ST_ISSUE;
                    end else begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign span_start_o = r_q.start;
    assign span_end_o   = r_q.lim;
    assign wr_o         = r_q.wr;
    assign sel_o        = r_q.sel;
    assign wdata_o      = r_q.wdata;
    assign done_o       = r_q.done;

endmodule

// File: rtl/ic_range_inv.sv
module ic_range_inv #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_end,
    output logic              req_done,
    input  logic              ic_enable,
    output logic              reg_wr,
    output logic              reg_sel,
    output logic [ADDR_W-1:0] reg_wdata,
    input  logic              eng_busy
);
    logic [ADDR_W-1:0] span_start, span_end, area, mask;

    ic_area_sizer #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_sizer (
        .span_start (span_start),
        .span_end   (span_end),
        .area       (area),
        .mask       (mask)
    );

    ic_inv_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_start    (req_start),
        .req_end      (req_end),
        .ic_enable    (ic_enable),
        .eng_busy     (eng_busy),
        .area_i       (area),
        .mask_i       (mask),
        .span_start_o (span_start),
        .span_end_o   (span_end),
        .wr_o         (reg_wr),
        .sel_o        (reg_sel),
        .wdata_o      (reg_wdata),
        .done_o       (req_done)
    );

endmodule

// File: rtl/ic_range_inv_chk.sv
module ic_range_inv_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_done,
    input logic              reg_wr,
    input logic              reg_sel,
    input logic [ADDR_W-1:0] reg_wdata,
    input logic              eng_busy
);
    logic [ADDR_W-1:0] inv_mask_p1;
    assign inv_mask_p1 = ~reg_wdata + ADDR_W'(1);

    // R4
    mask_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel) |-> $past(!eng_busy));

    // R4
    cmd_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel) |-> $past(!eng_busy, 2));

    // R6
    cmd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel) |-> reg_wdata[0]);

    // R3
    mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel) |-> ($countones(inv_mask_p1) == 1));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done);

    // R4
    no_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> !eng_busy);

endmodule

bind ic_range_inv ic_range_inv_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_done  (req_done),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .eng_busy  (eng_busy)
);

// File: tb/sim_ic_range_inv.sv
module sim_ic_range_inv;
    localparam int NV = 12;

    localparam logic [31:0] V_START [NV] = '{32'h1000, 32'h1010, 32'h1008, 32'h1030,
        32'h2000, 32'h2FF0, 32'h1000, 32'h400, 32'hFFFFFF00, 32'h1070, 32'h5000, 32'h0};
    localparam logic [31:0] V_END [NV] = '{32'h1040, 32'h1020, 32'h1030, 32'h1050,
        32'h3000, 32'h3010, 32'h2000, 32'h400, 32'hFFFFFFF0, 32'h10B0, 32'h1000, 32'h40000000};
    localparam logic V_EN [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1,
        1'b1, 1'b1, 1'b1, 1'b1};
    localparam logic [31:0] V_MASK [NV] = '{32'hFFFFFFC0, 32'hFFFFFFF0, 32'hFFFFFFC0,
        32'hFFFFFFE0, 32'hFFFFF000, 32'hFFFFFFE0, 32'h0, 32'h80000000, 32'hFFFFFF00,
        32'hFFFFFFC0, 32'h80000000, 32'hC0000000};
    localparam int V_NCMD [NV] = '{1, 1, 1, 2, 1, 2, 0, 1, 1, 2, 1, 1};
    localparam logic [31:0] V_FIRST [NV] = '{32'h1001, 32'h1011, 32'h1001, 32'h1021,
        32'h2001, 32'h2FE1, 32'h0, 32'h1, 32'hFFFFFF01, 32'h1041, 32'h1, 32'h1};
    localparam logic [31:0] V_LAST [NV] = '{32'h1001, 32'h1011, 32'h1001, 32'h1041,
        32'h2001, 32'h3001, 32'h0, 32'h1, 32'hFFFFFF01, 32'h1081, 32'h1, 32'h1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_start = '0, req_end = '0;
    logic        req_done;
    logic        ic_enable = 1'b1;
    logic        reg_wr, reg_sel;
    logic [31:0] reg_wdata;
    logic        eng_busy;
    logic        hold_busy = 1'b0;
    logic [1:0]  busy_cnt;

    int checks = 0, fails = 0;
    int n_mask, n_cmd, n_done, n_busy_wr, n_cmd_pre_mask;
    logic [31:0] seen_mask, seen_first, seen_last;

    always #4 clk = ~clk;

    ic_range_inv u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_start(req_start),
        .req_end(req_end), .req_done(req_done), .ic_enable(ic_enable),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .eng_busy(eng_busy)
    );

    // engine model: busy for three cycles after each command
    always_ff @(posedge clk) begin
        if (!rst_n)                 busy_cnt <= '0;
        else if (reg_wr && reg_sel) busy_cnt <= 2'd3;
        else if (busy_cnt != 0)     busy_cnt <= busy_cnt - 2'd1;
    end
    assign eng_busy = (busy_cnt != 0) || hold_busy;

    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr) begin
                if (eng_busy) n_busy_wr++;
                if (reg_sel) begin
                    n_cmd++;
                    if (n_mask == 0) n_cmd_pre_mask++;
                    if (n_cmd == 1) seen_first = reg_wdata;
                    seen_last = reg_wdata;
                end else begin
                    n_mask++;
                    seen_mask = reg_wdata;
                end
            end
            if (req_done) n_done++;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        n_mask = 0; n_cmd = 0; n_done = 0; n_busy_wr = 0; n_cmd_pre_mask = 0;
        seen_mask = '0; seen_first = '0; seen_last = '0;
    endtask

    task automatic issue(logic [31:0] s, logic [31:0] e, logic en);
        @(negedge clk);
        req_start = s; req_end = e; ic_enable = en; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (n_done == 0 && t < 300) begin
            @(negedge clk);
            t++;
        end
        if (n_done == 0) begin
            fails++;
            $display("FAIL R9 actual=no done expected=done pulse");
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 wr", {31'b0, reg_wr}, 32'h0);
        check("R11 done", {31'b0, req_done}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            clear_mon();
            issue(V_START[v], V_END[v], V_EN[v]);
            wait_done();
            check("R9 done count", n_done, 1);
            check("R4 writes while busy", n_busy_wr, 0);
            if (!V_EN[v]) begin
                check("R1 mask writes", n_mask, 0);
                check("R1 cmd writes", n_cmd, 0);
            end else begin
                check("R3 mask writes", n_mask, 1);
                check("R3 cmd before mask", n_cmd_pre_mask, 0);
                if (v == 7 || v == 10) check("R8 saturated mask", seen_mask, V_MASK[v]);
                else                   check("R2 mask", seen_mask, V_MASK[v]);
                check("R5 R6 first cmd", seen_first, V_FIRST[v]);
                check("R7 cmd count", n_cmd, V_NCMD[v]);
                check("R7 last cmd", seen_last, V_LAST[v]);
            end
        end

        // R4: busy held before the mask write
        clear_mon();
        hold_busy = 1'b1;
        issue(32'h1000, 32'h1040, 1'b1);
        repeat (8) @(negedge clk);
        check("R4 mask held off", n_mask, 0);
        hold_busy = 1'b0;
        wait_done();
        check("R4 mask after release", n_mask, 1);
        check("R4 cmd after release", n_cmd, 1);

        // R10: second request during a run is ignored
        clear_mon();
        issue(32'h1030, 32'h1050, 1'b1);
        issue(32'h8000, 32'h9000, 1'b1);
        wait_done();
        repeat (20) @(negedge clk);
        check("R10 cmd count", n_cmd, 2);
        check("R10 last cmd", seen_last, 32'h1041);
        check("R10 mask writes", n_mask, 1);
        check("R10 done count", n_done, 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule